// File: doc/BRIEF.md
# PLL Coefficient Change Sequencer

This block applies a new divider set (input divider M, feedback divider N, post divider PL) to a clock PLL without disturbing its consumers. On a start request it compares the requested M and PL with the values in the current coefficient register. If they match and the PLL is running, only N is moved, and a separate ramp engine glides it to the new value. If they differ, the block runs the full relock. It first glides N down to the divider for the minimum VCO frequency. It then halves the output divider and parks the output on the bypass clock. It powers the PLL up if needed, disables it, writes the coefficients and re-enables it. It waits for lock, returns the output to the VCO, restores the divider and glides N up to its target.

Every delay is counted in ticks of a one-microsecond strobe. A glide failure or a lock timeout during a sliding attempt causes one complete retry with gliding turned off: the new N is then written directly. The error flag that comes with `done` reflects only the last attempt. The minimum-VCO divider is ceil(M x VCO_MIN_MHZ / REF_MHZ), saturated at the largest N.

Top module: `pll_reprog_seq`

## Requirements
- R1: When gliding is allowed, the PLL is enabled and the requested M and PL equal `cur_m`/`cur_pl`, the only actions are one glide request to the new N followed by `done` with `err` low; no coefficient write, enable change or output switch occurs.
- R2: A glide whose target equals `cur_n` is skipped without raising `ramp_req`; the sequence proceeds as if it had succeeded.
- R3: On the full path with gliding allowed and the PLL enabled, N first glides to ceil(`cur_m` x VCO_MIN_MHZ / REF_MHZ), saturated at 2^NW-1; with the PLL disabled this glide is left out.
- R4: On the full path `div_half` rises first; `sel_vco` falls (bypass) only after at least SETTLE_US ticks have elapsed, and never while `div_half` is low.
- R5: If `pll_pwrdn` is set once bypass is selected, `pwrdn_clr` pulses and SETTLE_US ticks elapse before the next step; if it is clear, no pulse is issued.
- R6: `en_clr` pulses in the cycle immediately before `coef_wr`; the written N is the minimum-VCO divider of the new M when gliding, else the requested N.
- R7: `en_set` pulses right after the coefficient write; `lkdet_clr` then pulses only if `pll_lkdet_off` is set.
- R8: If `pll_lock` does not rise within LOCK_US ticks of enabling, the attempt fails.
- R9: After lock, `sel_vco` rises; `div_half` falls at least SETTLE_US ticks later; when gliding, N then glides to the requested value.
- R10: A failed gliding attempt (glide error or lock timeout) reruns the whole sequence once without gliding; `done` is a one-cycle pulse and `err` reports only the final attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin applying the requested coefficients (sampled while idle) |
| new_m | input | MW | Requested input divider |
| new_n | input | NW | Requested feedback divider |
| new_pl | input | PW | Requested post-divider code |
| cur_m | input | MW | Input divider held in the coefficient register |
| cur_n | input | NW | Feedback divider held in the coefficient register |
| cur_pl | input | PW | Post-divider code held in the coefficient register |
| pll_en | input | 1 | PLL enable status |
| pll_pwrdn | input | 1 | PLL low-power status |
| pll_lkdet_off | input | 1 | Lock detector disabled status |
| pll_lock | input | 1 | PLL lock status |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| ramp_done | input | 1 | Glide engine finished |
| ramp_err | input | 1 | Glide engine failed (valid with `ramp_done`) |
| ramp_req | output | 1 | One-cycle glide request |
| ramp_n | output | NW | Glide target N |
| sel_vco | output | 1 | Output source: 1 VCO, 0 bypass |
| div_half | output | 1 | Output divider: 1 halves (1:2), 0 passes (1:1) |
| en_set | output | 1 | Pulse: enable the PLL |
| en_clr | output | 1 | Pulse: disable the PLL |
| pwrdn_clr | output | 1 | Pulse: leave low-power state |
| lkdet_clr | output | 1 | Pulse: turn the lock detector back on |
| coef_wr | output | 1 | Pulse: write `coef_m`/`coef_n`/`coef_pl` |
| coef_m | output | MW | Input divider to write |
| coef_n | output | NW | Feedback divider to write |
| coef_pl | output | PW | Post-divider code to write |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Final attempt failed (valid with `done`) |

## Verification
A wrong state in this sequencer shows up as a control pulse that is misplaced, missing or duplicated in the ordered stream at the ports. Examples are a coefficient write that is not preceded by a disable, a bypass switch made before the divider is halved, or a glide to the wrong target. A wrong branch at the decision step changes the very first event of a request, one cycle after `start`. A miscounted delay moves the bypass or restore edge by whole microsecond ticks, and a missed retry surfaces as `done` with `err` where the rerun should have succeeded.

// File: rtl/pll_seq_pkg.sv
// Package: state encoding shared by the PLL coefficient change sequencer.
// Assumes nothing beyond a 4-bit state register.
package pll_seq_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_DECIDE, S_RAMP, S_RWAIT, S_DIV2, S_WBYP, S_PWR, S_WPWR,
        S_DIS, S_WRCOEF, S_EN, S_LKD, S_WLOCK, S_WDIV
    } seq_state_t;
endpackage

// File: rtl/pll_nlo_calc.sv
// Minimum-VCO feedback divider: ceil(m * VCO_MIN_MHZ / REF_MHZ), saturated
// to the largest NW-bit value. Purely combinational; assumes REF_MHZ > 0.
module pll_nlo_calc #(
    parameter int MW          = 8,
    parameter int NW          = 8,
    parameter int REF_MHZ     = 12,
    parameter int VCO_MIN_MHZ = 1000
) (
    input  logic [MW-1:0] m,
    output logic [NW-1:0] n_lo
);
    localparam int PRODW = MW + $clog2(VCO_MIN_MHZ + 1) + 2;
    localparam int NMAX  = (1 << NW) - 1;

    logic [PRODW-1:0] num;
    logic [PRODW-1:0] quo;

    // Rounded-up quotient, clamped to the divider field range.
    always_comb begin
        num  = PRODW'(m) * PRODW'(VCO_MIN_MHZ) + PRODW'(REF_MHZ - 1);
        quo  = num / PRODW'(REF_MHZ);
        n_lo = (quo > PRODW'(NMAX)) ? NW'(NMAX) : quo[NW-1:0];
    end
endmodule

// File: rtl/pll_us_timer.sv
// Microsecond down-counter. load presets the count (the tick in that cycle
// is ignored); each later tick decrements until zero. expired means zero.
module pll_us_timer #(
    parameter int CW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic          expired
);
    logic [CW-1:0] cnt;

    // Preset on load, otherwise count ticks down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (load)                 cnt <= load_val;
        else if (tick && cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    p_timer_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> (expired == $past(expired)));
endmodule

// File: rtl/pll_reprog_seq.sv
// PLL coefficient change sequencer. Chooses an N-only glide or a full
// relock through bypass, counts every wait in microsecond ticks and retries
// a failed gliding attempt once without gliding. Assumes status inputs
// reflect issued pulses within a cycle and SETTLE_US fits the timer width.
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int MW          = 8,
    parameter int NW          = 8,
    parameter int PW          = 6,
    parameter int REF_MHZ     = 12,
    parameter int VCO_MIN_MHZ = 1000,
    parameter int LOCK_US     = 300000,
    parameter int SETTLE_US   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [MW-1:0] new_m,
    input  logic [NW-1:0] new_n,
    input  logic [PW-1:0] new_pl,
    input  logic [MW-1:0] cur_m,
    input  logic [NW-1:0] cur_n,
    input  logic [PW-1:0] cur_pl,
    input  logic          pll_en,
    input  logic          pll_pwrdn,
    input  logic          pll_lkdet_off,
    input  logic          pll_lock,
    input  logic          us_tick,
    input  logic          ramp_done,
    input  logic          ramp_err,
    output logic          ramp_req,
    output logic [NW-1:0] ramp_n,
    output logic          sel_vco,
    output logic          div_half,
    output logic          en_set,
    output logic          en_clr,
    output logic          pwrdn_clr,
    output logic          lkdet_clr,
    output logic          coef_wr,
    output logic [MW-1:0] coef_m,
    output logic [NW-1:0] coef_n,
    output logic [PW-1:0] coef_pl,
    output logic          done,
    output logic          err
);
    localparam int CW = $clog2(LOCK_US + 1);

    seq_state_t    state, next_q;
    logic [MW-1:0] m_q;
    logic [NW-1:0] n_q;
    logic [PW-1:0] pl_q;
    logic          slide_q;
    logic [NW-1:0] nlo_old, nlo_new;
    logic          t_load, t_exp;
    logic [CW-1:0] t_val;

    pll_nlo_calc #(.MW(MW), .NW(NW), .REF_MHZ(REF_MHZ), .VCO_MIN_MHZ(VCO_MIN_MHZ))
        u_nlo_old (.m(cur_m), .n_lo(nlo_old));
    pll_nlo_calc #(.MW(MW), .NW(NW), .REF_MHZ(REF_MHZ), .VCO_MIN_MHZ(VCO_MIN_MHZ))
        u_nlo_new (.m(m_q), .n_lo(nlo_new));

    // Timer preset: settle delay on bypass, power-up and lock; lock window on enable.
    always_comb begin
        t_load = (state == S_DIV2) || (state == S_LKD) ||
                 (state == S_PWR && pll_pwrdn) || (state == S_WLOCK && pll_lock);
        t_val  = (state == S_LKD) ? CW'(LOCK_US) : CW'(SETTLE_US);
    end

    pll_us_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
        .tick(us_tick), .expired(t_exp)
    );

    // Main sequence: one control action per state, pulses last one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;  next_q <= S_IDLE;
            m_q <= '0;  n_q <= '0;  pl_q <= '0;  slide_q <= 1'b0;
            ramp_req <= 1'b0; ramp_n <= '0; sel_vco <= 1'b0; div_half <= 1'b0;
            en_set <= 1'b0; en_clr <= 1'b0; pwrdn_clr <= 1'b0; lkdet_clr <= 1'b0;
            coef_wr <= 1'b0; coef_m <= '0; coef_n <= '0; coef_pl <= '0;
            done <= 1'b0; err <= 1'b0;
        end else begin
            ramp_req <= 1'b0; en_set <= 1'b0; en_clr <= 1'b0; pwrdn_clr <= 1'b0;
            lkdet_clr <= 1'b0; coef_wr <= 1'b0; done <= 1'b0; err <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    m_q <= new_m;  n_q <= new_n;  pl_q <= new_pl;
                    slide_q <= 1'b1;
                    state <= S_DECIDE;
                end
                S_DECIDE: begin
                    if (slide_q && pll_en && m_q == cur_m && pl_q == cur_pl) begin
                        ramp_n <= n_q;  next_q <= S_IDLE;  state <= S_RAMP;
                    end else if (slide_q && pll_en) begin
                        ramp_n <= nlo_old;  next_q <= S_DIV2;  state <= S_RAMP;
                    end else begin
                        state <= S_DIV2;
                    end
                end
                S_RAMP: begin
                    if (ramp_n == cur_n) begin
                        state <= next_q;
                        done  <= (next_q == S_IDLE);
                    end else begin
                        ramp_req <= 1'b1;
                        state    <= S_RWAIT;
                    end
                end
                S_RWAIT: if (ramp_done) begin
                    if (ramp_err && slide_q) begin
                        slide_q <= 1'b0;  state <= S_DECIDE;
                    end else if (ramp_err) begin
                        done <= 1'b1;  err <= 1'b1;  state <= S_IDLE;
                    end else begin
                        state <= next_q;
                        done  <= (next_q == S_IDLE);
                    end
                end
                S_DIV2: begin
                    div_half <= 1'b1;
                    state    <= S_WBYP;
                end
                S_WBYP: if (t_exp) begin
                    sel_vco <= 1'b0;
                    state   <= S_PWR;
                end
                S_PWR: begin
                    pwrdn_clr <= pll_pwrdn;
                    state     <= pll_pwrdn ? S_WPWR : S_DIS;
                end
                S_WPWR: if (t_exp) state <= S_DIS;
                S_DIS: begin
                    en_clr <= 1'b1;
                    state  <= S_WRCOEF;
                end
                S_WRCOEF: begin
                    coef_wr <= 1'b1;
                    coef_m  <= m_q;
                    coef_n  <= slide_q ? nlo_new : n_q;
                    coef_pl <= pl_q;
                    state   <= S_EN;
                end
                S_EN: begin
                    en_set <= 1'b1;
                    state  <= S_LKD;
                end
                S_LKD: begin
                    lkdet_clr <= pll_lkdet_off;
                    state     <= S_WLOCK;
                end
                S_WLOCK: begin
                    if (pll_lock) begin
                        sel_vco <= 1'b1;  state <= S_WDIV;
                    end else if (t_exp && slide_q) begin
                        slide_q <= 1'b0;  state <= S_DECIDE;
                    end else if (t_exp) begin
                        done <= 1'b1;  err <= 1'b1;  state <= S_IDLE;
                    end
                end
                S_WDIV: if (t_exp) begin
                    div_half <= 1'b0;
                    if (slide_q) begin
                        ramp_n <= n_q;  next_q <= S_IDLE;  state <= S_RAMP;
                    end else begin
                        done <= 1'b1;  state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Coefficients are only written with the PLL just disabled.
    p_coef_after_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        coef_wr |-> $past(en_clr));
    // Bypass is only entered with the output divider already halved.
    p_bypass_halved_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_vco) |-> div_half);
    // Return to the VCO only follows an observed lock.
    p_vco_after_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_vco) |-> $past(pll_lock));
    // Divider restored only while the VCO drives the output.
    p_restore_in_vco_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(div_half) |-> sel_vco);
    // Completion is a single-cycle pulse.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // A glide is never requested towards the value already present.
    p_glide_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_req |-> (ramp_n != $past(cur_n)));
endmodule

// File: tb/pll_reprog_seq_bench.sv
module pll_reprog_seq_bench;
    localparam int MW = 8, NW = 8, PW = 6, SETTLE = 2;
    // Event kinds carried in the scoreboard queue.
    localparam logic [3:0] K_RAMP = 1, K_DIVH = 2, K_SEL = 3, K_PWR = 4, K_ENCLR = 5,
                           K_COEF = 6, K_ENSET = 7, K_LKD = 8, K_DONE = 9;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [MW-1:0] new_m = '0, cur_m = 8'd1;
    logic [NW-1:0] new_n = '0, cur_n = 8'd100;
    logic [PW-1:0] new_pl = '0, cur_pl = 6'd1;
    logic pll_en = 1'b0, pll_pwrdn = 1'b1, pll_lkdet_off = 1'b1, pll_lock = 1'b0;
    logic us_tick = 1'b0, ramp_done = 1'b0, ramp_err = 1'b0;
    logic ramp_req, sel_vco, div_half, en_set, en_clr, pwrdn_clr, lkdet_clr, coef_wr, done, err;
    logic [NW-1:0] ramp_n, coef_n;
    logic [MW-1:0] coef_m;
    logic [PW-1:0] coef_pl;

    pll_reprog_seq #(.LOCK_US(40), .SETTLE_US(SETTLE)) u_pll_reprog_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .new_m(new_m), .new_n(new_n),
        .new_pl(new_pl), .cur_m(cur_m), .cur_n(cur_n), .cur_pl(cur_pl),
        .pll_en(pll_en), .pll_pwrdn(pll_pwrdn), .pll_lkdet_off(pll_lkdet_off),
        .pll_lock(pll_lock), .us_tick(us_tick), .ramp_done(ramp_done),
        .ramp_err(ramp_err), .ramp_req(ramp_req), .ramp_n(ramp_n),
        .sel_vco(sel_vco), .div_half(div_half), .en_set(en_set), .en_clr(en_clr),
        .pwrdn_clr(pwrdn_clr), .lkdet_clr(lkdet_clr), .coef_wr(coef_wr),
        .coef_m(coef_m), .coef_n(coef_n), .coef_pl(coef_pl), .done(done), .err(err)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0, failures = 0, cyc = 0, ticks = 0, lock_cnt = 0, ramp_cnt = 0;
    logic [31:0] exp_q[$];
    logic prev_sel = 1'b0, prev_div = 1'b0, done_seen = 1'b0;
    logic lock_ok = 1'b1, fail_once = 1'b0;
    logic [NW-1:0] ramp_tgt = '0;

    function automatic string req_of(logic [3:0] k);
        case (k)
            K_RAMP:  return "R1 R3";
            K_DIVH:  return "R4 R9";
            K_SEL:   return "R4 R9";
            K_PWR:   return "R5";
            K_ENCLR: return "R6";
            K_COEF:  return "R6";
            K_ENSET: return "R7";
            K_LKD:   return "R7";
            default: return "R8 R10";
        endcase
    endfunction

    function automatic logic [NW-1:0] nlo(int m);
        int q = (m * 1000 + 11) / 12;
        return (q > 255) ? 8'd255 : NW'(q);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] k, input int v);
        exp_q.push_back({k, 28'(v)});
    endtask

    function automatic int cf(int m, int n, int pl);
        return (m << 14) | (n << 6) | pl;
    endfunction

    // Monitor: compares each observed event with the scoreboard head.
    task automatic got(input logic [3:0] k, input int v);
        logic [31:0] e;
        if (exp_q.size() == 0) begin
            check(1'b0, req_of(k), {k, 28'(v)}, 0);
        end else begin
            e = exp_q.pop_front();
            check(e == {k, 28'(v)}, req_of(e[31:28]), {k, 28'(v)}, e);
        end
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Sample outputs, update the PLL/glide model, then drive the tick.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            check(1'b0, "watchdog", cyc, 0);
            report();
        end
        if (rst_n) begin
            if (ramp_req) begin got(K_RAMP, ramp_n); ramp_tgt = ramp_n; ramp_cnt = 3; end
            if (div_half != prev_div) begin
                got(K_DIVH, div_half);
                if (!div_half) check(ticks >= SETTLE, "R9", ticks, SETTLE);
                ticks = 0;
            end
            if (sel_vco != prev_sel) begin
                got(K_SEL, sel_vco);
                if (!sel_vco) check(ticks >= SETTLE, "R4", ticks, SETTLE);
                ticks = 0;
            end
            if (pwrdn_clr) begin got(K_PWR, 0); pll_pwrdn = 1'b0; end
            if (en_clr) begin got(K_ENCLR, 0); pll_en = 1'b0; lock_cnt = 0; end
            if (coef_wr) begin
                got(K_COEF, cf(coef_m, coef_n, coef_pl));
                cur_m = coef_m; cur_n = coef_n; cur_pl = coef_pl;
            end
            if (en_set) begin got(K_ENSET, 0); pll_en = 1'b1; lock_cnt = 0; end
            if (lkdet_clr) begin got(K_LKD, 0); pll_lkdet_off = 1'b0; end
            if (done) begin got(K_DONE, err); done_seen = 1'b1; end
            prev_div = div_half; prev_sel = sel_vco;
        end
        ramp_done = 1'b0; ramp_err = 1'b0;
        if (ramp_cnt > 0) begin
            ramp_cnt--;
            if (ramp_cnt == 0) begin
                ramp_done = 1'b1; ramp_err = fail_once;
                if (!fail_once) cur_n = ramp_tgt;
                fail_once = 1'b0;
            end
        end
        if (pll_en && lock_ok && lock_cnt < 5) lock_cnt++;
        pll_lock = pll_en && lock_ok && lock_cnt >= 5;
        us_tick = (cyc % 4 == 0);
        if (us_tick) ticks++;
    end

    task automatic run_case(input int m, input int n, input int pl, input string tag);
        @(negedge clk);
        new_m = MW'(m); new_n = NW'(n); new_pl = PW'(pl); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done_seen) @(negedge clk);
        done_seen = 1'b0;
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // Reset state: bypass, divider 1:1, idle.
        check(sel_vco == 1'b0 && div_half == 1'b0, "R4", {sel_vco, div_half}, 0);
        check(done == 1'b0 && ramp_req == 1'b0, "R10", {done, ramp_req}, 0);
        check(coef_wr == 1'b0 && en_set == 1'b0, "R6", {coef_wr, en_set}, 0);
        rst_n = 1'b1;

        // R3 R5 R7: PLL off and powered down, so full path with no glide down.
        push(K_DIVH, 1); push(K_PWR, 0); push(K_ENCLR, 0);
        push(K_COEF, cf(1, nlo(1), 1)); push(K_ENSET, 0); push(K_LKD, 0);
        push(K_SEL, 1); push(K_DIVH, 0); push(K_RAMP, 150); push(K_DONE, 0);
        run_case(1, 150, 1, "R5");

        // R1: same M and PL with PLL on, glide only.
        push(K_RAMP, 120); push(K_DONE, 0);
        run_case(1, 120, 1, "R1");

        // R2: target N already present, no glide at all.
        push(K_DONE, 0);
        run_case(1, 120, 1, "R2");

        // R3 R6 R9: full path with glide down to n_lo of the old M.
        push(K_RAMP, nlo(1)); push(K_DIVH, 1); push(K_SEL, 0); push(K_ENCLR, 0);
        push(K_COEF, cf(3, nlo(3), 2)); push(K_ENSET, 0);
        push(K_SEL, 1); push(K_DIVH, 0); push(K_RAMP, 200); push(K_DONE, 0);
        run_case(3, 200, 2, "R9");

        // R10: glide-down fails, rerun without gliding writes N directly; R7 lock detect on.
        pll_lkdet_off = 1'b1; fail_once = 1'b1;
        push(K_RAMP, nlo(3)); push(K_DIVH, 1); push(K_SEL, 0); push(K_ENCLR, 0);
        push(K_COEF, cf(4, 230, 2)); push(K_ENSET, 0); push(K_LKD, 0);
        push(K_SEL, 1); push(K_DIVH, 0); push(K_DONE, 0);
        run_case(4, 230, 2, "R10");

        // R3: n_lo of M=4 saturates at 255.
        push(K_RAMP, 255); push(K_DIVH, 1); push(K_SEL, 0); push(K_ENCLR, 0);
        push(K_COEF, cf(4, 255, 3)); push(K_ENSET, 0);
        push(K_SEL, 1); push(K_DIVH, 0); push(K_RAMP, 240); push(K_DONE, 0);
        run_case(4, 240, 3, "R3");

        // R8 R10: lock never comes; both attempts time out, err on the final one.
        lock_ok = 1'b0;
        push(K_RAMP, 255); push(K_DIVH, 1); push(K_SEL, 0); push(K_ENCLR, 0);
        push(K_COEF, cf(2, nlo(2), 3)); push(K_ENSET, 0);
        push(K_ENCLR, 0); push(K_COEF, cf(2, 180, 3)); push(K_ENSET, 0);
        push(K_DONE, 1);
        run_case(2, 180, 3, "R8");

        report();
    end
endmodule